// File: doc/BRIEF.md
# HDMI Vendor Capability Block Decoder

This block decodes the vendor-specific data block that a display sink places in its capability extension. The block's payload arrives one byte per cycle on a valid strobe. The payload length, as declared in the data block header, is loaded together with a synchronous start pulse. The decoder first compares the three-byte registration identifier with the HDMI value. On a match it captures the source physical address, the sink's capability flags, the maximum TMDS clock and up to four latency values. Each latency value is converted from its half-millisecond code to milliseconds.

Every decoded field is a register with a valid bit of its own. Optional fields that the declared length does not reach stay invalid. Latency fields also depend on the flag byte that comes before them, so the meaning of a byte position is only known once the earlier bytes have been seen. A one-cycle done pulse marks the end of the declared payload. A sticky format-error flag collects every rule violation. A not-HDMI status reports a foreign identifier, and in that case the rest of the block is skipped without decoding.

Top module: `hdmi_vdb_parser`

## Requirements
- R1: A start pulse clears every field, every valid bit, `id_match`, `not_hdmi` (unless the length is zero) and `fmt_err`, and loads `pay_len`. A byte strobed in the same cycle as start is ignored.
- R2: Payload bytes 0..2 must be 0x03, 0x0C, 0x00. On a match `id_match` rises. Otherwise, or when the length is below 3, `not_hdmi` rises and the later bytes change no field and raise no error.
- R3: Bytes 3 (low) and 4 (high) form `src_addr`. `src_addr_vld` rises with byte 4.
- R4: Byte 5 loads `sink_caps` as {bit7 AI, bit6 48-bit, bit5 36-bit, bit4 30-bit, bit3 deep-colour 4:4:4, bit0 dual-link} in bits 5..0. `sink_caps_vld` rises with it. A nonzero bit 2 or bit 1 sets `fmt_err`.
- R5: Byte 6 sets `tmds_mhz` to 5 times its value, with `tmds_vld` high only when the byte is nonzero.
- R6: In byte 7, bit 7 enables the progressive latency bytes 8 and 9, and bit 6 together with bit 7 enables the interlaced bytes 10 and 11. Bit 6 without bit 7 sets `fmt_err`, and bytes 10 and 11 are then treated as trailing bytes. Nonzero bits 5..0 set `fmt_err`.
- R7: An enabled latency byte c goes to `lat_ms[k]`, where k is 0 for video, 1 for audio, 2 for interlaced video and 3 for interlaced audio. A code in 1..251 gives (c-1)*2 ms with the valid bit set. Code 0 gives 0 with the valid bit clear. A code above 251 gives 0 with the valid bit clear and sets `fmt_err`.
- R8: Any byte in a matching block that is not a defined, enabled field must be zero, or `fmt_err` is set.
- R9: `done` is high for exactly one cycle, in the cycle after the last declared byte, or in the cycle after start when the length is 0. Fields past the declared length stay invalid.
- R10: Bytes strobed while no block is being parsed change nothing.
- R11: `fmt_err` stays set until the next start.
- R12: Each field updates in the cycle after its byte is accepted and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new block; clears all outputs |
| pay_len | input | LEN_W | Declared payload length, sampled with start |
| in_vld | input | 1 | Payload byte strobe |
| in_byte | input | 8 | Payload byte |
| done | output | 1 | One-cycle end-of-block pulse |
| id_match | output | 1 | HDMI identifier recognised |
| not_hdmi | output | 1 | Identifier foreign or incomplete |
| fmt_err | output | 1 | Sticky format error |
| src_addr | output | 16 | Source physical address |
| src_addr_vld | output | 1 | `src_addr` valid |
| sink_caps | output | 6 | Capability flags |
| sink_caps_vld | output | 1 | `sink_caps` valid |
| tmds_mhz | output | 11 | Maximum TMDS clock in MHz |
| tmds_vld | output | 1 | `tmds_mhz` valid |
| lat_ms | output | 4x9 | Latencies in ms: [0] video, [1] audio, [2] interlaced video, [3] interlaced audio |
| lat_vld | output | 4 | Per-latency valid bits |

## Verification
On every cycle the assertions check several invariants. The done pulse never lasts two cycles. The TMDS value is a nonzero multiple of 5 whenever it is valid, and every valid latency is even and no larger than 500 ms. `id_match` and `not_hdmi` are never both set, a skipped block never shows decoded fields, the error flag holds until start, and fields hold steady when no byte is strobed.

Some behaviours depend on position and on the content of earlier bytes, and only the bench scenarios can show them. These include the byte-order assembly of the address, the latency bytes that the flag byte enables or turns into trailing bytes, and the code-to-millisecond conversion at 0, 1, 251 and 252. The same holds for truncation by the declared length and for restart partway through a block.

// File: rtl/vdb_pkg.sv
package vdb_pkg;

  localparam int MS_W     = 9;
  localparam int MHZ_W    = 11;
  localparam int CAPS_W   = 6;
  localparam int N_LAT    = 4;
  localparam int MAX_CODE = 251;

  localparam int POS_ADDR_LO = 3;
  localparam int POS_ADDR_HI = 4;
  localparam int POS_CAPS    = 5;
  localparam int POS_TMDS    = 6;
  localparam int POS_LFLAG   = 7;
  localparam int POS_LAT0    = 8;
  localparam int POS_ILAT0   = 10;
  localparam int POS_END     = 12;

  typedef enum logic [2:0] {
    ROLE_ID,
    ROLE_ADDR_LO,
    ROLE_ADDR_HI,
    ROLE_CAPS,
    ROLE_TMDS,
    ROLE_LFLAG,
    ROLE_LAT,
    ROLE_TAIL
  } byte_role_e;

  function automatic logic [7:0] id_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    id_byte = 8'h03;
      2'd1:    id_byte = 8'h0C;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/vdb_seq.sv
module vdb_seq #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             in_vld,
  output logic             accept,
  output logic [LEN_W-1:0] idx,
  output logic             last,
  output logic             done
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             busy;
  logic [LEN_W-1:0] len_q;

  assign accept = in_vld && busy && !start;
  assign last   = accept && (idx == len_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      len_q <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        idx   <= '0;
        len_q <= len;
        busy  <= (len != '0);
        done  <= (len == '0);
      end else if (accept) begin
        idx <= idx + ONE;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vdb_role_dec.sv
module vdb_role_dec
  import vdb_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [LEN_W-1:0] idx,
  input  logic             lat_on,
  input  logic             ilat_on,
  output byte_role_e       role,
  output logic [1:0]       slot
);

  always_comb begin
    role = ROLE_TAIL;
    slot = 2'd0;
    if (int'(idx) < POS_ADDR_LO) begin
      role = ROLE_ID;
    end else if (int'(idx) == POS_ADDR_LO) begin
      role = ROLE_ADDR_LO;
    end else if (int'(idx) == POS_ADDR_HI) begin
      role = ROLE_ADDR_HI;
    end else if (int'(idx) == POS_CAPS) begin
      role = ROLE_CAPS;
    end else if (int'(idx) == POS_TMDS) begin
      role = ROLE_TMDS;
    end else if (int'(idx) == POS_LFLAG) begin
      role = ROLE_LFLAG;
    end else if (int'(idx) < POS_ILAT0) begin
      if (lat_on) begin
        role = ROLE_LAT;
        slot = idx[1:0];
      end
    end else if (int'(idx) < POS_END) begin
      if (ilat_on) begin
        role = ROLE_LAT;
        slot = idx[1:0];
      end
    end
  end

endmodule

// File: rtl/vdb_lat_conv.sv
module vdb_lat_conv
  import vdb_pkg::*;
(
  input  logic [7:0]      code,
  output logic [MS_W-1:0] ms,
  output logic            vld,
  output logic            bad
);

  logic [7:0] code_m1;

  assign code_m1 = code - 8'd1;

  always_comb begin
    bad = (int'(code) > MAX_CODE);
    vld = (code != 8'd0) && !bad;
    ms  = vld ? {code_m1, 1'b0} : '0;
  end

endmodule

// File: rtl/hdmi_vdb_parser.sv
module hdmi_vdb_parser
  import vdb_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [LEN_W-1:0]           pay_len,
  input  logic                       in_vld,
  input  logic [7:0]                 in_byte,
  output logic                       done,
  output logic                       id_match,
  output logic                       not_hdmi,
  output logic                       fmt_err,
  output logic [15:0]                src_addr,
  output logic                       src_addr_vld,
  output logic [CAPS_W-1:0]          sink_caps,
  output logic                       sink_caps_vld,
  output logic [MHZ_W-1:0]           tmds_mhz,
  output logic                       tmds_vld,
  output logic [N_LAT-1:0][MS_W-1:0] lat_ms,
  output logic [N_LAT-1:0]           lat_vld
);

  localparam logic [LEN_W-1:0] ID_LAST = LEN_W'(2);

  logic             acc;
  logic             last;
  logic [LEN_W-1:0] idx;
  byte_role_e       role;
  logic [1:0]       slot;
  logic             lat_on;
  logic             ilat_on;
  logic             id_ok;
  logic             id_hit;
  logic [MS_W-1:0]  conv_ms;
  logic             conv_vld;
  logic             conv_bad;
  logic             decode;
  logic [MHZ_W-1:0] byte_x5;

  vdb_seq #(.LEN_W(LEN_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .len    (pay_len),
    .in_vld (in_vld),
    .accept (acc),
    .idx    (idx),
    .last   (last),
    .done   (done)
  );

  vdb_role_dec #(.LEN_W(LEN_W)) u_role (
    .idx     (idx),
    .lat_on  (lat_on),
    .ilat_on (ilat_on),
    .role    (role),
    .slot    (slot)
  );

  vdb_lat_conv u_conv (
    .code (in_byte),
    .ms   (conv_ms),
    .vld  (conv_vld),
    .bad  (conv_bad)
  );

  assign id_hit  = (in_byte == id_byte(idx[1:0]));
  assign decode  = acc && id_match;
  assign byte_x5 = ({3'b000, in_byte} << 2) + {3'b000, in_byte};

  // identifier, status and scalar fields
  always_ff @(posedge clk) begin
    if (rst) begin
      id_ok         <= 1'b0;
      id_match      <= 1'b0;
      not_hdmi      <= 1'b0;
      fmt_err       <= 1'b0;
      src_addr      <= '0;
      src_addr_vld  <= 1'b0;
      sink_caps     <= '0;
      sink_caps_vld <= 1'b0;
      tmds_mhz      <= '0;
      tmds_vld      <= 1'b0;
      lat_on        <= 1'b0;
      ilat_on       <= 1'b0;
    end else if (start) begin
      id_ok         <= 1'b0;
      id_match      <= 1'b0;
      not_hdmi      <= (pay_len == '0);
      fmt_err       <= 1'b0;
      src_addr      <= '0;
      src_addr_vld  <= 1'b0;
      sink_caps     <= '0;
      sink_caps_vld <= 1'b0;
      tmds_mhz      <= '0;
      tmds_vld      <= 1'b0;
      lat_on        <= 1'b0;
      ilat_on       <= 1'b0;
    end else if (acc) begin
      if (role == ROLE_ID) begin
        id_ok <= (idx == '0) ? id_hit : (id_ok && id_hit);
        if (idx == ID_LAST) begin
          if (id_ok && id_hit) id_match <= 1'b1;
          else                 not_hdmi <= 1'b1;
        end else if (last) begin
          not_hdmi <= 1'b1;
        end
      end else if (decode) begin
        case (role)
          ROLE_ADDR_LO: src_addr[7:0] <= in_byte;
          ROLE_ADDR_HI: begin
            src_addr[15:8] <= in_byte;
            src_addr_vld   <= 1'b1;
          end
          ROLE_CAPS: begin
            sink_caps     <= {in_byte[7:3], in_byte[0]};
            sink_caps_vld <= 1'b1;
            if (in_byte[2:1] != 2'b00) fmt_err <= 1'b1;
          end
          ROLE_TMDS: begin
            tmds_mhz <= byte_x5;
            tmds_vld <= (in_byte != 8'd0);
          end
          ROLE_LFLAG: begin
            lat_on  <= in_byte[7];
            ilat_on <= in_byte[7] && in_byte[6];
            if ((in_byte[6] && !in_byte[7]) || (in_byte[5:0] != 6'd0))
              fmt_err <= 1'b1;
          end
          ROLE_LAT: begin
            if (conv_bad) fmt_err <= 1'b1;
          end
          default: begin
            if (in_byte != 8'd0) fmt_err <= 1'b1;
          end
        endcase
      end
    end
  end

  // one capture register per latency slot
  for (genvar k = 0; k < N_LAT; k++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst || start) begin
        lat_ms[k]  <= '0;
        lat_vld[k] <= 1'b0;
      end else if (decode && role == ROLE_LAT && slot == 2'(k)) begin
        lat_ms[k]  <= conv_ms;
        lat_vld[k] <= conv_vld;
      end
    end
  end

endmodule

// File: rtl/vdb_parser_chk.sv
module vdb_parser_chk
  import vdb_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic                       in_vld,
  input logic                       done,
  input logic                       id_match,
  input logic                       not_hdmi,
  input logic                       fmt_err,
  input logic [15:0]                src_addr,
  input logic                       src_addr_vld,
  input logic                       sink_caps_vld,
  input logic [MHZ_W-1:0]           tmds_mhz,
  input logic                       tmds_vld,
  input logic [N_LAT-1:0][MS_W-1:0] lat_ms,
  input logic [N_LAT-1:0]           lat_vld
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done);

  // R5
  tmds_scale_chk: assert property (@(posedge clk) disable iff (rst)
    tmds_vld |-> (tmds_mhz != '0) && ((tmds_mhz % 5) == 0));

  // R7
  for (genvar k = 0; k < N_LAT; k++) begin : g_lat_chk
    lat_range_chk: assert property (@(posedge clk) disable iff (rst)
      lat_vld[k] |-> (int'(lat_ms[k]) <= 500) && !lat_ms[k][0]);
  end

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !fmt_err && !id_match && !src_addr_vld && !sink_caps_vld
              && !tmds_vld && (lat_vld == '0));

  // R2
  id_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(id_match && not_hdmi));

  // R2
  skip_chk: assert property (@(posedge clk) disable iff (rst)
    not_hdmi |-> !src_addr_vld && !sink_caps_vld && !tmds_vld && (lat_vld == '0));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_err && !start |=> fmt_err);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start && !in_vld |=> $stable(src_addr) && $stable(tmds_mhz)
                          && $stable(lat_ms) && $stable(lat_vld));

endmodule

bind hdmi_vdb_parser vdb_parser_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .in_vld        (in_vld),
  .done          (done),
  .id_match      (id_match),
  .not_hdmi      (not_hdmi),
  .fmt_err       (fmt_err),
  .src_addr      (src_addr),
  .src_addr_vld  (src_addr_vld),
  .sink_caps_vld (sink_caps_vld),
  .tmds_mhz      (tmds_mhz),
  .tmds_vld      (tmds_vld),
  .lat_ms        (lat_ms),
  .lat_vld       (lat_vld)
);

// File: tb/hdmi_vdb_parser_bench.sv
module hdmi_vdb_parser_bench;

  localparam int LEN_W = 5;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [LEN_W-1:0]     pay_len = '0;
  logic                 in_vld = 1'b0;
  logic [7:0]           in_byte = '0;
  logic                 done, id_match, not_hdmi, fmt_err;
  logic [15:0]          src_addr;
  logic                 src_addr_vld;
  logic [5:0]           sink_caps;
  logic                 sink_caps_vld;
  logic [10:0]          tmds_mhz;
  logic                 tmds_vld;
  logic [3:0][8:0]      lat_ms;
  logic [3:0]           lat_vld;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hdmi_vdb_parser #(.LEN_W(LEN_W)) u_hdmi_vdb_parser (
    .clk, .rst, .start, .pay_len, .in_vld, .in_byte,
    .done, .id_match, .not_hdmi, .fmt_err,
    .src_addr, .src_addr_vld, .sink_caps, .sink_caps_vld,
    .tmds_mhz, .tmds_vld, .lat_ms, .lat_vld
  );

  // behavioural reference state
  int m_busy, m_len, m_idx, m_done, m_ok, m_match, m_nh, m_err;
  int m_addr, m_avld, m_caps, m_cvld, m_tmds, m_tvld, m_lon, m_ilon;
  int m_ms[4];
  int m_lv[4];

  task automatic m_clear();
    m_ok = 0; m_match = 0; m_nh = 0; m_err = 0;
    m_addr = 0; m_avld = 0; m_caps = 0; m_cvld = 0;
    m_tmds = 0; m_tvld = 0; m_lon = 0; m_ilon = 0;
    for (int k = 0; k < 4; k++) begin m_ms[k] = 0; m_lv[k] = 0; end
  endtask

  task automatic m_latency(input int k, input int b);
    if (b > 251) m_err = 1;
    m_lv[k] = (b >= 1 && b <= 251) ? 1 : 0;
    m_ms[k] = m_lv[k] ? (b - 1) * 2 : 0;
  endtask

  task automatic m_byte(input int p, input int b);
    int idb[3] = '{8'h03, 8'h0C, 8'h00};
    if (p < 3) begin
      m_ok = (p == 0) ? (b == idb[0]) : (m_ok && b == idb[p]);
      if (p == 2) begin
        if (m_ok) m_match = 1; else m_nh = 1;
      end
    end else if (m_match) begin
      if (p == 3) m_addr = (m_addr & 16'hFF00) | b;
      else if (p == 4) begin m_addr = (m_addr & 16'h00FF) | (b << 8); m_avld = 1; end
      else if (p == 5) begin
        m_caps = ((b >> 3) << 1) | (b & 1);
        m_cvld = 1;
        if ((b & 8'h06) != 0) m_err = 1;
      end else if (p == 6) begin m_tmds = b * 5; m_tvld = (b != 0); end
      else if (p == 7) begin
        m_lon  = (b >> 7) & 1;
        m_ilon = m_lon && ((b >> 6) & 1);
        if ((((b >> 6) & 1) && !m_lon) || (b & 8'h3F) != 0) m_err = 1;
      end else if ((p == 8 || p == 9) && m_lon) m_latency(p - 8, b);
      else if ((p == 10 || p == 11) && m_ilon) m_latency(p - 8, b);
      else if (b != 0) m_err = 1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_len = 0; m_idx = 0; m_done = 0;
      m_clear();
    end else begin
      m_done = 0;
      if (start) begin
        m_clear();
        m_len  = int'(pay_len);
        m_idx  = 0;
        m_busy = (m_len != 0);
        m_done = (m_len == 0);
        m_nh   = (m_len == 0);
      end else if (in_vld && m_busy) begin
        m_byte(m_idx, int'(in_byte));
        if (m_idx == m_len - 1) begin
          m_busy = 0;
          m_done = 1;
          if (m_idx < 2) m_nh = 1;
        end
        m_idx++;
      end
    end
  end

  task automatic chk(input string req, input string fld, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, fld, act, exp, cyc);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R9",  "done",         int'(done),          m_done);
      chk("R2",  "id_match",     int'(id_match),      m_match);
      chk("R2",  "not_hdmi",     int'(not_hdmi),      m_nh);
      chk("R11", "fmt_err",      int'(fmt_err),       m_err);
      chk("R3",  "src_addr",     int'(src_addr),      m_addr);
      chk("R3",  "src_addr_vld", int'(src_addr_vld),  m_avld);
      chk("R4",  "sink_caps",    int'(sink_caps),     m_caps);
      chk("R4",  "sink_caps_vld",int'(sink_caps_vld), m_cvld);
      chk("R5",  "tmds_mhz",     int'(tmds_mhz),      m_tmds);
      chk("R5",  "tmds_vld",     int'(tmds_vld),      m_tvld);
      for (int k = 0; k < 4; k++) begin
        chk("R7", "lat_ms",  int'(lat_ms[k]),  m_ms[k]);
        chk("R7", "lat_vld", int'(lat_vld[k]), m_lv[k]);
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // R1: start pulse, with a stray strobed byte that must be ignored
  task automatic begin_blk(input int len);
    start   = 1'b1;
    pay_len = LEN_W'(len);
    in_vld  = 1'b1;
    in_byte = 8'hAA;
    @(negedge clk);
    start  = 1'b0;
    in_vld = 1'b0;
  endtask

  task automatic send(input int b[$], input int gap);
    foreach (b[i]) begin
      in_vld  = 1'b1;
      in_byte = 8'(b[i]);
      @(negedge clk);
      in_vld = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic block(input int len, input int b[$], input int gap);
    begin_blk(len);
    send(b, gap);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset err",  int'(fmt_err),  0);
    chk("R1", "reset lat",  int'(lat_vld),  0);

    // full block, all four latencies: 20 ms, 40 ms, unknown, 500 ms (R6 R7 R12)
    block(14, '{8'h03, 8'h0C, 8'h00, 8'h21, 8'h43, 8'hB9, 8'h3C, 8'hC0,
                8'h0B, 8'h15, 8'h00, 8'hFB, 8'h00, 8'h00}, 0);
    chk("R3", "addr",  int'(src_addr), 16'h4321);
    chk("R7", "ilat",  int'(lat_ms[3]), 500);

    // short block: latency fields beyond length stay invalid (R9)
    block(7, '{8'h03, 8'h0C, 8'h00, 8'h00, 8'h10, 8'h08, 8'h00}, 1);
    chk("R9", "lat beyond len", int'(lat_vld), 0);

    // foreign identifier: skipped, no error (R2)
    block(8, '{8'h03, 8'h0D, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 0);
    chk("R2", "skip no err", int'(fmt_err), 0);

    // interlaced flag without progressive flag, nonzero trailing byte (R6 R8)
    block(12, '{8'h03, 8'h0C, 8'h00, 8'h00, 8'h10, 8'h00, 8'h64, 8'h40,
                8'h00, 8'h00, 8'h00, 8'h05}, 2);

    // reserved caps bits, max TMDS, latency code 252 and code 1 (R4 R5 R7)
    block(10, '{8'h03, 8'h0C, 8'h00, 8'h00, 8'h10, 8'h06, 8'hFF, 8'h80,
                8'hFC, 8'h01}, 0);
    chk("R5", "tmds max", int'(tmds_mhz), 1275);

    // zero length and length 2 (R9 R2)
    block(0, '{}, 0);
    block(2, '{8'h03, 8'h0C}, 0);

    // R10: bytes while idle
    send('{8'h55, 8'h66, 8'h77}, 0);

    // restart partway through a block (R1 R11)
    begin_blk(12);
    send('{8'h03, 8'h0C, 8'h00, 8'h01, 8'h02, 8'h02}, 0);
    block(13, '{8'h03, 8'h0C, 8'h00, 8'h00, 8'h20, 8'h79, 8'h1E, 8'hC0,
                8'h02, 8'h03, 8'h04, 8'h05, 8'h07}, 1);
    chk("R8", "trail err", int'(fmt_err), 1);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule